// File: doc/BRIEF.md
# Programmable SPI Master Shift Engine

This block is the serial core of an SPI master with one data lane. It takes transmit words from a show-ahead transmit FIFO interface and returns received words to a receive FIFO interface. It generates the serial clock, the data-out line and the chip select. Software programs the following settings while the engine is idle: the clock divider, the word length, the bit order, the clock idle level, the launch edge and the chip-select idle level.

There are two ways to start a frame. The data path runs a full-duplex frame of one or more words. The transmit and receive enables can be used alone, which gives a transmit-only frame or a receive-only frame. The command path sends one to four bytes held in a 32-bit command word and returns no receive data. The block raises single-cycle status pulses for a separate interrupt block: frame end, data-path done, transmit underflow and receive overflow.

Top module: `spi_xfer_eng`

## Requirements
- R1: Each half-period of the serial clock lasts div_i+1 core clocks. The first edge of a frame comes div_i+1 cycles after the start is taken.
- R2: fmt_i selects the word length: 0 gives 8 bits, 1 gives 12, 2 gives 16 and 3 gives 32. Shorter words are right-justified on tx_data_i and rx_data_o, and the unused upper bits of rx_data_o are zero.
- R3: With msb_first_i=1 each word goes out and comes in most significant bit first. With msb_first_i=0 it goes least significant bit first.
- R4: Outside a frame sclk_o rests at cpol_i. After the final sampling edge it returns to the latched idle level.
- R5: When drive_pos_i=1, mosi_o changes on rising sclk edges and miso_i is sampled on falling edges. When drive_pos_i=0 these roles are swapped. If the first edge of a frame is a launch edge, bit 0 of the first word is already on the line before it.
- R6: With multi_i=1 a data frame carries len_i+1 words. With multi_i=0 it carries exactly one word, whatever len_i holds.
- R7: A pulse on cmd_start_i while idle sends 8*(cmd_nbytes_i+1) bits taken from cmd_i[8N-1:0], following the bit order in R3. A command frame pops nothing, pushes nothing and does not raise done_o.
- R8: frame_end_o pulses exactly one core clock after the final sampling edge of any frame, and busy_o is low at that moment. done_o pulses together with it only for data frames.
- R9: If tx_empty_i is high when a word is loaded and transmit is enabled, tx_uflow_o pulses for one cycle, an all-zero word is sent and nothing is popped. tx_pop_o is never asserted while tx_empty_i is high.
- R10: If rx_full_i is high when a word completes and receive is enabled, rx_oflow_o pulses, the word is dropped and rx_push_o stays low.
- R11: A frame started with rx_en_i alone sends zero words and never pops. A frame started with tx_en_i alone never pushes a word and never flags overflow.
- R12: When cs_sw_mode_i=1, cs_o equals cs_sw_val_i. When cs_sw_mode_i=0, cs_o is ~cs_idle_i while busy and cs_idle_i otherwise.
- R13: In a frame with receive enabled, every transmitted word produces exactly one push of the matching received word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | 16 | Clock divider value |
| fmt_i | input | 2 | Word length select |
| msb_first_i | input | 1 | 1 = MSB first |
| cpol_i | input | 1 | Serial clock idle level |
| drive_pos_i | input | 1 | 1 = launch data on the rising edge |
| cs_idle_i | input | 1 | Chip-select idle level |
| cs_sw_mode_i | input | 1 | Chip select under software control |
| cs_sw_val_i | input | 1 | Software chip-select value |
| multi_i | input | 1 | Multi-word frame enable |
| len_i | input | 16 | Word count minus one |
| tx_en_i | input | 1 | Data-path transmit start/enable |
| rx_en_i | input | 1 | Data-path receive start/enable |
| cmd_i | input | 32 | Command bytes |
| cmd_nbytes_i | input | 2 | Command byte count minus one |
| cmd_start_i | input | 1 | Command-path start |
| tx_data_i | input | 32 | Head word of the transmit FIFO |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_pop_o | output | 1 | Consume the head transmit word |
| rx_data_o | output | 32 | Received word |
| rx_full_i | input | 1 | Receive FIFO full |
| rx_push_o | output | 1 | Push rx_data_o |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 1 | Chip select |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Data frame finished (pulse) |
| frame_end_o | output | 1 | Any frame finished (pulse) |
| tx_uflow_o | output | 1 | Transmit underflow (pulse) |
| rx_oflow_o | output | 1 | Receive overflow (pulse) |

## Verification
Several properties are checked on every cycle:
- no pop from an empty transmit FIFO;
- no push into a full receive FIFO, and never a push and an overflow in the same cycle;
- done_o only together with frame_end_o, and frame_end_o only once the engine is idle;
- a serial clock that follows cpol_i between frames.

Other behaviour can only be shown by the bench's scenarios, because it depends on whole bit streams and cycle counts:
- the bit order and right-justification of each word format;
- the placement of the launch and sampling edges in all four clock modes;
- the exact cycle of frame end for each divider value;
- the command byte selection;
- the zero fill after an underflow.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} st_e;

  function automatic int fmt_width(input logic [1:0] fmt);
    case (fmt)
      2'd0: return 8;
      2'd1: return 12;
      2'd2: return 16;
      default: return 32;
    endcase
  endfunction
endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_word_asm.sv
module spi_word_asm #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              smp_i,
  input  logic [IDX_W-1:0]  pos_i,
  input  logic              miso_i,
  output logic [DATA_W-1:0] next_o
);
  logic [DATA_W-1:0] word_q;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign next_o[i] = (smp_i && pos_i == IDX_W'(i)) ? miso_i : word_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    word_q <= '0;
    else if (clr_i) word_q <= '0;
    else if (smp_i) word_q <= next_o;
  end
endmodule

// File: rtl/spi_cs_drv.sv
module spi_cs_drv (
  input  logic sw_mode_i,
  input  logic sw_val_i,
  input  logic idle_lvl_i,
  input  logic active_i,
  output logic cs_o
);
  always_comb begin
    if (sw_mode_i) cs_o = sw_val_i;
    else           cs_o = active_i ? ~idle_lvl_i : idle_lvl_i;
  end
endmodule

// File: rtl/spi_xfer_eng.sv
module spi_xfer_eng
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [1:0]        fmt_i,
  input  logic              msb_first_i,
  input  logic              cpol_i,
  input  logic              drive_pos_i,
  input  logic              cs_idle_i,
  input  logic              cs_sw_mode_i,
  input  logic              cs_sw_val_i,
  input  logic              multi_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic [DATA_W-1:0] cmd_i,
  input  logic [1:0]        cmd_nbytes_i,
  input  logic              cmd_start_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_empty_i,
  output logic              tx_pop_o,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic              rx_full_i,
  output logic              rx_push_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              frame_end_o,
  output logic              tx_uflow_o,
  output logic              rx_oflow_o
);
  localparam int SEL_W = $clog2(DATA_W);
  localparam int IDX_W = SEL_W + 1;

  st_e st_q;
  logic sclk_q, cpol_q, drv_q, msb_q, cmd_q, tx_act_q, rx_act_q, pend_q;
  logic [IDX_W-1:0] w_q, tx_bit_q, rx_bit_q, tx_pos, rx_pos, w_fmt, w_cmd;
  logic [DATA_W-1:0] tx_word_q, rx_next, rx_data_q;
  logic [LEN_W-1:0] left_q;
  logic push_q, fe_q, done_q, uf_q, of_q;
  logic tick, idle, start_cmd, start_data, launch, smp, load_mid, use_tx;
  logic uf_now, last_bit, word_done, last_word;

  always_comb begin
    idle       = (st_q == ST_IDLE);
    start_cmd  = idle && cmd_start_i;
    start_data = idle && !cmd_start_i && (tx_en_i || rx_en_i);
    launch     = tick && (drv_q ^ sclk_q);
    smp        = tick && !(drv_q ^ sclk_q);
    load_mid   = launch && pend_q;
    use_tx     = start_data ? tx_en_i : (load_mid && tx_act_q);
    tx_pop_o   = use_tx && !tx_empty_i;
    uf_now     = use_tx && tx_empty_i;
    last_bit   = (rx_bit_q == w_q - 1'b1);
    word_done  = smp && last_bit;
    last_word  = (left_q == '0);
    tx_pos     = msb_q ? (w_q - 1'b1 - tx_bit_q) : tx_bit_q;
    rx_pos     = msb_q ? (w_q - 1'b1 - rx_bit_q) : rx_bit_q;
    w_fmt      = IDX_W'(fmt_width(fmt_i));
    w_cmd      = IDX_W'({cmd_nbytes_i + 2'd0, 3'b000}) + IDX_W'(8);
  end

  spi_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (st_q == ST_RUN),
    .div_i (div_i),
    .tick_o(tick)
  );

  spi_word_asm #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_asm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (start_cmd || start_data || load_mid),
    .smp_i (smp),
    .pos_i (rx_pos),
    .miso_i(miso_i),
    .next_o(rx_next)
  );

  spi_cs_drv u_cs (
    .sw_mode_i (cs_sw_mode_i),
    .sw_val_i  (cs_sw_val_i),
    .idle_lvl_i(cs_idle_i),
    .active_i  (!idle),
    .cs_o      (cs_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      sclk_q    <= 1'b0;
      cpol_q    <= 1'b0;
      drv_q     <= 1'b0;
      msb_q     <= 1'b1;
      cmd_q     <= 1'b0;
      tx_act_q  <= 1'b0;
      rx_act_q  <= 1'b0;
      pend_q    <= 1'b0;
      w_q       <= IDX_W'(8);
      tx_bit_q  <= '0;
      rx_bit_q  <= '0;
      tx_word_q <= '0;
      left_q    <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          sclk_q   <= cpol_i;
          tx_bit_q <= '0;
          rx_bit_q <= '0;
          pend_q   <= 1'b0;
          if (start_cmd || start_data) begin
            st_q   <= ST_RUN;
            cpol_q <= cpol_i;
            drv_q  <= drive_pos_i;
            msb_q  <= msb_first_i;
            cmd_q  <= start_cmd;
          end
          if (start_cmd) begin
            w_q       <= w_cmd;
            tx_word_q <= cmd_i;
            left_q    <= '0;
            tx_act_q  <= 1'b0;
            rx_act_q  <= 1'b0;
          end else if (start_data) begin
            w_q       <= w_fmt;
            tx_word_q <= tx_pop_o ? tx_data_i : '0;
            left_q    <= multi_i ? len_i : '0;
            tx_act_q  <= tx_en_i;
            rx_act_q  <= rx_en_i;
          end
        end
        ST_RUN: begin
          if (tick) sclk_q <= ~sclk_q;
          if (launch) begin
            if (pend_q) begin
              // next word goes on the line at the first launch after the last sample
              tx_word_q <= tx_pop_o ? tx_data_i : '0;
              tx_bit_q  <= '0;
              pend_q    <= 1'b0;
            end else if (rx_bit_q != '0) begin
              tx_bit_q <= tx_bit_q + 1'b1;
            end
          end
          if (smp) begin
            if (last_bit) begin
              rx_bit_q <= '0;
              if (last_word) st_q <= ST_FIN;
              else begin
                pend_q <= 1'b1;
                left_q <= left_q - 1'b1;
              end
            end else begin
              rx_bit_q <= rx_bit_q + 1'b1;
            end
          end
        end
        default: begin
          sclk_q <= cpol_q;
          st_q   <= ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      push_q    <= 1'b0;
      of_q      <= 1'b0;
      uf_q      <= 1'b0;
      fe_q      <= 1'b0;
      done_q    <= 1'b0;
      rx_data_q <= '0;
    end else begin
      push_q <= word_done && rx_act_q && !rx_full_i;
      of_q   <= word_done && rx_act_q && rx_full_i;
      uf_q   <= uf_now;
      fe_q   <= (st_q == ST_FIN);
      done_q <= (st_q == ST_FIN) && !cmd_q;
      if (word_done) rx_data_q <= rx_next;
    end
  end

  assign sclk_o      = sclk_q;
  assign mosi_o      = tx_word_q[tx_pos[SEL_W-1:0]];
  assign rx_data_o   = rx_data_q;
  assign rx_push_o   = push_q;
  assign rx_oflow_o  = of_q;
  assign tx_uflow_o  = uf_q;
  assign frame_end_o = fe_q;
  assign done_o      = done_q;
  assign busy_o      = !idle;
endmodule

// File: rtl/spi_xfer_eng_chk.sv
module spi_xfer_eng_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cpol_i,
  input logic tx_empty_i,
  input logic tx_pop_o,
  input logic rx_full_i,
  input logic rx_push_o,
  input logic rx_oflow_o,
  input logic sclk_o,
  input logic busy_o,
  input logic done_o,
  input logic frame_end_o
);
  // R9
  no_empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> !tx_empty_i);

  // R10
  push_xor_oflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_push_o, rx_oflow_o}));

  // R10
  no_full_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> $past(!rx_full_i));

  // R8
  done_with_fe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> frame_end_o);

  // R8
  fe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |-> !busy_o);

  // R4
  idle_sclk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(!busy_o) && !busy_o) |-> (sclk_o == $past(cpol_i)));
endmodule

bind spi_xfer_eng spi_xfer_eng_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpol_i     (cpol_i),
  .tx_empty_i (tx_empty_i),
  .tx_pop_o   (tx_pop_o),
  .rx_full_i  (rx_full_i),
  .rx_push_o  (rx_push_o),
  .rx_oflow_o (rx_oflow_o),
  .sclk_o     (sclk_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .frame_end_o(frame_end_o)
);

// File: tb/sim_spi_xfer_eng.sv
`timescale 1ns/1ps
module sim_spi_xfer_eng;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] div_i = '0, len_i = '0;
  logic [1:0]  fmt_i = '0, cmd_nbytes_i = '0;
  logic msb_first_i = 1'b1, cpol_i = 1'b0, drive_pos_i = 1'b0, cs_idle_i = 1'b1;
  logic cs_sw_mode_i = 1'b0, cs_sw_val_i = 1'b0, multi_i = 1'b0;
  logic tx_en_i = 1'b0, rx_en_i = 1'b0, cmd_start_i = 1'b0, rx_full_i = 1'b0;
  logic [31:0] cmd_i = '0;
  logic [31:0] tx_data_i, rx_data_o;
  logic tx_empty_i, tx_pop_o, rx_push_o, sclk_o, mosi_o, miso_i, cs_o;
  logic busy_o, done_o, frame_end_o, tx_uflow_o, rx_oflow_o;

  always #2.5 clk = ~clk;

  logic [31:0] tx_mem [0:255];
  logic [31:0] rx_mem [0:255];
  int tx_rd = 0, tx_lim = 0, rx_wr = 0;
  int n_fe = 0, n_done = 0, n_uf = 0, n_of = 0;
  bit mb [0:1023];
  bit mo [0:1023];
  int sc = 0, sbase = 0;
  bit b_drv = 1'b0;
  int nchk = 0, nfail = 0;

  assign tx_data_i  = tx_mem[8'(tx_rd)];
  assign tx_empty_i = (tx_rd >= tx_lim);
  assign miso_i     = mb[10'(sc - sbase)];

  spi_xfer_eng u0 (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div_i), .fmt_i(fmt_i),
    .msb_first_i(msb_first_i), .cpol_i(cpol_i), .drive_pos_i(drive_pos_i),
    .cs_idle_i(cs_idle_i), .cs_sw_mode_i(cs_sw_mode_i), .cs_sw_val_i(cs_sw_val_i),
    .multi_i(multi_i), .len_i(len_i), .tx_en_i(tx_en_i), .rx_en_i(rx_en_i),
    .cmd_i(cmd_i), .cmd_nbytes_i(cmd_nbytes_i), .cmd_start_i(cmd_start_i),
    .tx_data_i(tx_data_i), .tx_empty_i(tx_empty_i), .tx_pop_o(tx_pop_o),
    .rx_data_o(rx_data_o), .rx_full_i(rx_full_i), .rx_push_o(rx_push_o),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i), .cs_o(cs_o),
    .busy_o(busy_o), .done_o(done_o), .frame_end_o(frame_end_o),
    .tx_uflow_o(tx_uflow_o), .rx_oflow_o(rx_oflow_o)
  );

  always @(posedge clk) begin
    if (tx_pop_o)    tx_rd <= tx_rd + 1;
    if (rx_push_o)   begin rx_mem[8'(rx_wr)] <= rx_data_o; rx_wr <= rx_wr + 1; end
    if (frame_end_o) n_fe <= n_fe + 1;
    if (done_o)      n_done <= n_done + 1;
    if (tx_uflow_o)  n_uf <= n_uf + 1;
    if (rx_oflow_o)  n_of <= n_of + 1;
  end

  // slave model: capture mosi on sampling edges while selected
  always @(sclk_o) begin
    if (cs_o != cs_idle_i && sclk_o == !b_drv) begin
      mo[10'(sc)] <= mosi_o;
      sc <= sc + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int fw(input int f);
    return (f == 0) ? 8 : (f == 1) ? 12 : (f == 2) ? 16 : 32;
  endfunction
  function automatic logic [31:0] wmask(input int w);
    return (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
  endfunction
  function automatic logic [31:0] txw(input int i, input int f);
    return (32'hA5C3_0F96 ^ (32'(i) * 32'h1357_9BDF) ^ 32'(f << 5)) & wmask(fw(f));
  endfunction
  function automatic logic [31:0] sww(input int i, input int f, input int md);
    return (32'h3C5A_96E1 + 32'(i) * 32'h0246_8ACE + 32'(md)) & wmask(fw(f));
  endfunction

  // wait for frame end; returns cycles counted from the start edge
  task automatic wait_fe(output int c);
    c = 0;
    forever begin
      @(posedge clk); c++;
      @(negedge clk);
      if (frame_end_o) break;
      if (c > 20000) begin
        chk(1'b0, "R8", "watchdog expired", c, 0);
        break;
      end
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic data_frame(input int md, input int f, input bit msb, input int nw,
                            input int dv, input bit te, input bit re, input int avail,
                            input bit full, input bit multi);
    int w, c, k, bad, first_bad, e_fe, e_pop, e_uf, e_of, e_rx;
    int fe0, dn0, uf0, of0, rx0, rd0, s0;
    logic [31:0] tw, rw;
    bit eb;
    w = fw(f);
    @(negedge clk);
    cpol_i = md[1]; drive_pos_i = md[1] ^ md[0]; b_drv = md[1] ^ md[0];
    fmt_i = 2'(f); msb_first_i = msb; div_i = 16'(dv); multi_i = multi;
    len_i = multi ? 16'(nw - 1) : 16'd7;
    rx_full_i = full;
    for (int i = 0; i < avail; i++) tx_mem[8'(tx_rd + i)] = txw(i, f);
    tx_lim = tx_rd + avail;
    sbase = sc;
    for (int i = 0; i < nw; i++)
      for (int j = 0; j < w; j++) begin
        rw = sww(i, f, md);
        mb[10'(i * w + j)] = msb ? rw[w - 1 - j] : rw[j];
      end
    @(negedge clk); @(negedge clk);
    fe0 = n_fe; dn0 = n_done; uf0 = n_uf; of0 = n_of; rx0 = rx_wr; rd0 = tx_rd; s0 = sc;
    tx_en_i = te; rx_en_i = re;
    @(posedge clk); @(negedge clk);
    tx_en_i = 1'b0; rx_en_i = 1'b0;
    wait_fe(c);
    k = 2 * w * nw - (md[0] ? 0 : 1);
    chk(c == k * (dv + 1) + 1, "R1", "frame end cycle", c, k * (dv + 1) + 1);
    chk(n_fe - fe0 == 1 && n_done - dn0 == 1, "R8", "frame end/done pulses",
        n_fe - fe0 + 16 * (n_done - dn0), 17);
    chk(sc - s0 == nw * w, "R6", "sampled bits", sc - s0, nw * w);
    bad = 0; first_bad = -1;
    for (int i = 0; i < nw; i++) begin
      tw = (te && i < avail) ? txw(i, f) : 32'd0;
      for (int j = 0; j < w; j++) begin
        eb = msb ? tw[w - 1 - j] : tw[j];
        if (mo[10'(s0 + i * w + j)] != eb) begin
          bad++;
          if (first_bad < 0) first_bad = i * w + j;
        end
      end
    end
    chk(bad == 0, msb ? "R3" : "R5", "mosi bit mismatches (first index in actual)",
        first_bad, -1);
    e_pop = te ? ((avail < nw) ? avail : nw) : 0;
    e_uf  = te ? ((avail < nw) ? nw - avail : 0) : 0;
    e_of  = (re && full) ? nw : 0;
    e_rx  = (re && !full) ? nw : 0;
    chk(tx_rd - rd0 == e_pop, "R11", "pops", tx_rd - rd0, e_pop);
    chk(n_uf - uf0 == e_uf, "R9", "underflow pulses", n_uf - uf0, e_uf);
    chk(n_of - of0 == e_of, "R10", "overflow pulses", n_of - of0, e_of);
    chk(rx_wr - rx0 == e_rx, "R13", "pushed words", rx_wr - rx0, e_rx);
    for (int i = 0; i < e_rx && i < rx_wr - rx0; i++)
      chk(rx_mem[8'(rx0 + i)] === sww(i, f, md), "R2", "received word",
          rx_mem[8'(rx0 + i)], sww(i, f, md));
    chk(sclk_o == cpol_i && !busy_o, "R4", "idle clock level", sclk_o, cpol_i);
  endtask

  task automatic cmd_frame(input int n, input bit msb, input int md, input int dv);
    int w, c, k, bad, fe0, dn0, rx0, rd0, s0;
    logic [31:0] cv;
    bit eb;
    w = 8 * n;
    cv = 32'hC1A5_7E39;
    @(negedge clk);
    cpol_i = md[1]; drive_pos_i = md[1] ^ md[0]; b_drv = md[1] ^ md[0];
    msb_first_i = msb; div_i = 16'(dv); rx_full_i = 1'b0;
    sbase = sc;
    for (int j = 0; j < 64; j++) mb[10'(j)] = 1'b1;
    @(negedge clk); @(negedge clk);
    fe0 = n_fe; dn0 = n_done; rx0 = rx_wr; rd0 = tx_rd; s0 = sc;
    cmd_i = cv; cmd_nbytes_i = 2'(n - 1); cmd_start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_start_i = 1'b0;
    wait_fe(c);
    k = 2 * w - (md[0] ? 0 : 1);
    chk(c == k * (dv + 1) + 1, "R8", "command frame end cycle", c, k * (dv + 1) + 1);
    chk(sc - s0 == w, "R7", "command bits", sc - s0, w);
    bad = 0;
    for (int j = 0; j < w; j++) begin
      eb = msb ? cv[w - 1 - j] : cv[j];
      if (mo[10'(s0 + j)] != eb) bad++;
    end
    chk(bad == 0, "R7", "command bit mismatches", bad, 0);
    chk(rx_wr == rx0 && tx_rd == rd0, "R7", "command fifo activity",
        (rx_wr - rx0) + (tx_rd - rd0), 0);
    chk(n_fe - fe0 == 1 && n_done == dn0, "R7", "command pulses",
        (n_fe - fe0) + 16 * (n_done - dn0), 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin tx_mem[i] = '0; rx_mem[i] = '0; end
    #12 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && sclk_o == 1'b0 && cs_o == 1'b1, "R12", "reset outputs",
        {busy_o, sclk_o, cs_o}, 3'b001);
    chk(!tx_pop_o && !rx_push_o && !frame_end_o && !done_o, "R8", "reset pulses",
        {tx_pop_o, rx_push_o, frame_end_o, done_o}, 0);
    // R12: software chip select
    cs_sw_mode_i = 1'b1; cs_sw_val_i = 1'b0;
    @(negedge clk);
    chk(cs_o == 1'b0, "R12", "sw cs low", cs_o, 0);
    cs_sw_val_i = 1'b1;
    @(negedge clk);
    chk(cs_o == 1'b1, "R12", "sw cs high", cs_o, 1);
    cs_sw_mode_i = 1'b0;
    // R2 R3 R5: sweep modes, formats, orders
    for (int md = 0; md < 4; md++)
      for (int f = 0; f < 4; f++)
        for (int o = 0; o < 2; o++)
          data_frame(md, f, o[0], 2, 1, 1'b1, 1'b1, 2, 1'b0, 1'b1);
    // R1: divider sweep
    for (int dv = 0; dv < 4; dv++) data_frame(dv, 0, 1'b1, 3, dv, 1'b1, 1'b1, 3, 1'b0, 1'b1);
    // R6: single word with multi off ignores len
    data_frame(0, 1, 1'b1, 1, 2, 1'b1, 1'b1, 4, 1'b0, 1'b0);
    tx_lim = tx_rd;
    // R12: active-high chip select
    cs_idle_i = 1'b0;
    data_frame(3, 2, 1'b0, 2, 0, 1'b1, 1'b1, 2, 1'b0, 1'b1);
    cs_idle_i = 1'b1;
    // R9: underflow after 2 of 5
    data_frame(1, 0, 1'b1, 5, 0, 1'b1, 1'b1, 2, 1'b0, 1'b1);
    // R10: receive full
    data_frame(2, 0, 1'b0, 3, 0, 1'b1, 1'b1, 3, 1'b1, 1'b1);
    // R11: receive only, then transmit only
    data_frame(0, 3, 1'b1, 2, 0, 1'b0, 1'b1, 2, 1'b0, 1'b1);
    tx_lim = tx_rd;
    data_frame(1, 2, 1'b1, 2, 0, 1'b1, 1'b0, 2, 1'b0, 1'b1);
    // R7: command path
    for (int n = 1; n <= 4; n++) begin
      cmd_frame(n, 1'b1, n - 1, 1);
      cmd_frame(n, 1'b0, 4 - n, 0);
    end
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule